// File: doc/BRIEF.md
# Cyclic-shift odd-inversion chip spreader

The block turns a stream of 4-bit data symbols into a serial stream of spreading chips. Only one root code word is held. Each of the 16 code words is derived from it as the symbol is accepted, by a cyclic rotation, by inverting the chips at odd positions, or by both. The derived word is then framed with an optional cyclic-prefix chip, a copy of its final chip placed ahead of chip 0, and shifted out one chip per chip-enable strobe.

The code length is a parameter. In the 8-chip build the prefix chip is always present, so each symbol occupies 9 chip slots. In the 16-chip build a second parameter chooses between 16 and 17 chip slots. Symbols arrive on a valid/ready handshake, and a symbol-start flag marks the first chip of each symbol. The handshake takes the next symbol on the same strobe that sends the last chip of the current one, so back-to-back symbols leave no gap. Chip value 1 stands for +1 and 0 for -1.

Top module: `cobi_spreader`

## Requirements
- R1: The root code word is 0x5C for the 8-chip build and 0x2F53 for the 16-chip build, with chip index 0 being the most significant bit. For symbol s, chip i of the rotated word equals root chip (i + r) mod N, where r = s[2:0] times 1 (8-chip) or times 2 (16-chip). Symbol 0 gives the unmodified root.
- R2: When s[3] is 1, every odd-indexed chip (1, 3, 5, ...) of the rotated word is inverted. When s[3] is 0, no chip is inverted.
- R3: In the 8-chip build every symbol is sent as 9 chips. The first is an extension chip equal to code-word chip 7, followed by code-word chips 0 to 7.
- R4: In the 16-chip build, parameter EXT_LONG = 0 sends exactly the 16 code-word chips with no extension chip. EXT_LONG = 1 prefixes a copy of chip 15.
- R5: Chips go out in rising index order. One chip is consumed on each clock where chip_en is high while chip_valid is high. While chip_en is low, chip_out, chip_valid and sym_start hold their values.
- R6: sym_start is high exactly on the first chip slot of each symbol (the extension chip when present) and low on every other chip.
- R7: sym_ready is high when no symbol is in flight, or when the last chip is being sent with chip_en high. At every other point it is low. A stream of symbols with chip_en high every clock produces chip_valid high without a break.
- R8: After reset, and whenever no symbol is in flight, chip_valid, chip_out and sym_start are 0.
- R9: The 16 code words observed at the serial output in each build are pairwise distinct.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_en | input | 1 | Chip strobe; one chip is consumed per high clock |
| sym_valid | input | 1 | A symbol is offered on sym_data |
| sym_ready | output | 1 | The offered symbol is taken on this clock |
| sym_data | input | 4 | Data symbol; bit 3 selects odd-chip inversion, bits 2:0 the rotation |
| chip_out | output | 1 | Current chip, 1 = +1, 0 = -1 |
| chip_valid | output | 1 | chip_out carries a chip of a symbol |
| sym_start | output | 1 | Current chip is the first slot of a symbol |

## Verification
The hardest situation to reach from the ports is the handover at the final chip of a symbol. Acceptance there must coincide with the chip_en strobe, and a strobe that is absent on that clock must hold the symbol off. The stimulus reaches it with long back-to-back runs under a strobe every clock, which exercises the same-clock handover 15 times in a row in each build. It then repeats the runs with a strobe on every second or third clock, so that the last chip sits idle for several clocks with a symbol waiting. A directed case loads a symbol with the strobe held low, checks that the ready signal stays low and the prefix chip stays put, and then resets in the middle of a symbol.

// File: rtl/cobi_spreader_pkg.sv
// Package: shared constants for the chip spreader.
// Assumes only the two supported code lengths, 8 and 16.
package cobi_spreader_pkg;

    localparam int SYM_W = 4;

    // Root code word for a code length; chip 0 is the most significant bit.
    function automatic logic [15:0] root_code(input int n);
        return (n == 8) ? 16'h005C : 16'h2F53;
    endfunction

endpackage

// File: rtl/cobi_codegen.sv
// Module: cobi_codegen
// Derives one code word from the stored root. It rotates the root left by
// sym[2:0]*STEP chips and then inverts the odd-indexed chips when sym[3] is set.
// Assumes N is a power of two, so the rotation index wraps by truncation.
module cobi_codegen #(
    parameter int           N    = 8,
    parameter int           STEP = 1,
    parameter logic [N-1:0] ROOT = '0
) (
    input  logic [3:0]   sym,
    output logic [N-1:0] word
);
    localparam int RW = $clog2(N);

    logic [RW-1:0] rot;

    // Purpose: rotation amount from the low symbol bits.
    always_comb begin
        rot = RW'(int'(sym[2:0]) * STEP);
    end

    // Purpose: one output chip per position; chip i sits at bit N-1-i.
    for (genvar i = 0; i < N; i++) begin : g_chip
        logic [RW-1:0] src;
        always_comb begin
            src = RW'(i) + rot;
            word[N-1-i] = ROOT[~src] ^ (sym[3] & ((i % 2) == 1));
        end
    end
endmodule

// File: rtl/cobi_framer.sv
// Module: cobi_framer
// Builds the transmit frame from a code word. With EXT = 1 it places a copy of
// the final chip ahead of chip 0 as a cyclic prefix. The frame MSB goes out first.
module cobi_framer #(
    parameter int N   = 8,
    parameter int EXT = 1,
    localparam int L  = N + EXT
) (
    input  logic [N-1:0] word,
    output logic [L-1:0] frame
);
    if (EXT != 0) begin : g_prefix
        // Purpose: prefix the last chip (bit 0) ahead of the word.
        always_comb frame = {word[0], word};
    end else begin : g_plain
        // Purpose: pass the word through unchanged.
        always_comb frame = word;
    end
endmodule

// File: rtl/cobi_serializer.sv
// Module: cobi_serializer
// Shifts an L-chip frame out MSB first, one chip per chip_en clock. A new frame
// is loaded when idle, or on the clock that consumes the last chip.
// Assumes L >= 2.
module cobi_serializer #(
    parameter int  L  = 9,
    localparam int CW = $clog2(L + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         chip_en,
    input  logic         load_valid,
    output logic         load_ready,
    input  logic [L-1:0] frame_in,
    output logic         chip_out,
    output logic         chip_valid,
    output logic         first_chip
);
    logic [L-1:0]  shreg;
    logic [CW-1:0] remain;
    logic          first_q;
    logic          accept;

    // Purpose: handshake; take a frame when idle or on the final chip strobe.
    always_comb begin
        load_ready = (remain == '0) || ((remain == CW'(1)) && chip_en);
        accept     = load_valid && load_ready;
    end

    // Purpose: frame shift register, chip counter and first-slot flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            remain  <= '0;
            first_q <= 1'b0;
        end else if (accept) begin
            shreg   <= frame_in;
            remain  <= CW'(L);
            first_q <= 1'b1;
        end else if (chip_en && (remain != '0)) begin
            shreg   <= shreg << 1;
            remain  <= remain - CW'(1);
            first_q <= 1'b0;
        end
    end

    // Purpose: present the current chip; idle level is 0.
    always_comb begin
        chip_valid = (remain != '0);
        chip_out   = chip_valid & shreg[L-1];
        first_chip = first_q;
    end

    AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && load_ready) |=> (chip_valid && first_chip)); // R6
    AST_HOLD_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_valid && !chip_en) |=> (chip_valid && $stable(chip_out) && $stable(first_chip))); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_valid |-> (!chip_out && !first_chip)); // R8
    AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_valid && !chip_en) |-> !load_ready); // R7
    AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_valid && chip_en && load_valid && load_ready) |=> chip_valid); // R7
endmodule

// File: rtl/cobi_spreader.sv
// Module: cobi_spreader (top)
// 4-bit symbol to chip spreader. It derives the code word from a single root,
// frames it with an optional cyclic-prefix chip and serializes it.
// Assumes CHIPS is 8 or 16; the 8-chip build always carries the prefix chip.
module cobi_spreader #(
    parameter int CHIPS    = 8,
    parameter int EXT_LONG = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chip_en,
    input  logic       sym_valid,
    output logic       sym_ready,
    input  logic [3:0] sym_data,
    output logic       chip_out,
    output logic       chip_valid,
    output logic       sym_start
);
    import cobi_spreader_pkg::*;

    localparam int              EXT       = (CHIPS == 8) ? 1 : ((EXT_LONG != 0) ? 1 : 0);
    localparam int              STEP      = CHIPS / 8;
    localparam int              FRAME_LEN = CHIPS + EXT;
    localparam logic [15:0]     ROOT_FULL = root_code(CHIPS);
    localparam logic [CHIPS-1:0] ROOT     = ROOT_FULL[CHIPS-1:0];

    logic [CHIPS-1:0]     word;
    logic [FRAME_LEN-1:0] frame;

    cobi_codegen #(.N(CHIPS), .STEP(STEP), .ROOT(ROOT)) u_codegen (
        .sym  (sym_data),
        .word (word)
    );

    cobi_framer #(.N(CHIPS), .EXT(EXT)) u_framer (
        .word  (word),
        .frame (frame)
    );

    cobi_serializer #(.L(FRAME_LEN)) u_serializer (
        .clk        (clk),
        .rst_n      (rst_n),
        .chip_en    (chip_en),
        .load_valid (sym_valid),
        .load_ready (sym_ready),
        .frame_in   (frame),
        .chip_out   (chip_out),
        .chip_valid (chip_valid),
        .first_chip (sym_start)
    );
endmodule

// File: tb/cobi_spreader_bench.sv
module cobi_spreader_bench;
    localparam int CLK_PERIOD = 10;

    // Stimulus table: {symbol, expected 8-chip code word}.
    localparam logic [11:0] VEC [16] = '{
        {4'd0, 8'h5C}, {4'd1, 8'hB8}, {4'd2, 8'h71}, {4'd3, 8'hE2},
        {4'd4, 8'hC5}, {4'd5, 8'h8B}, {4'd6, 8'h17}, {4'd7, 8'h2E},
        {4'd8, 8'h09}, {4'd9, 8'hED}, {4'd10, 8'h24}, {4'd11, 8'hB7},
        {4'd12, 8'h90}, {4'd13, 8'hDE}, {4'd14, 8'h42}, {4'd15, 8'h7B}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chip_en = 1'b0;
    logic [3:0] sym_data = '0;
    logic vld_s = 1'b0, vld_l = 1'b0;
    logic rdy_s, co_s, cv_s, st_s;
    logic rdy_l, co_l, cv_l, st_l;

    int errors = 0;
    int checks = 0;

    int seq [64];
    int seq_n;
    bit obs_c [1100];
    bit obs_st [1100];
    logic [15:0] seen [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    cobi_spreader u_cobi_spreader (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .sym_valid(vld_s),
        .sym_ready(rdy_s), .sym_data(sym_data), .chip_out(co_s),
        .chip_valid(cv_s), .sym_start(st_s)
    );

    cobi_spreader #(.CHIPS(16), .EXT_LONG(0)) u_long (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .sym_valid(vld_l),
        .sym_ready(rdy_l), .sym_data(sym_data), .chip_out(co_l),
        .chip_valid(cv_l), .sym_start(st_l)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Software model of the code words (R1, R2).
    function automatic logic [15:0] sw_word(input int n, input int s);
        logic [15:0] root;
        logic [15:0] w;
        int rot;
        root = (n == 8) ? 16'h005C : 16'h2F53;
        rot = (s % 8) * (n / 8);
        w = '0;
        for (int i = 0; i < n; i++) begin
            logic c;
            c = root[n - 1 - ((i + rot) % n)];
            if (s >= 8 && (i % 2) == 1) c = ~c;
            w[n - 1 - i] = c;
        end
        return w;
    endfunction

    // Drive seq through one build; mode 0 = 8-chip, 1 = 16-chip. en_period = strobe spacing.
    task automatic run_stream(input int mode, input int en_period, input bit record_words);
        int n, len, ext, n_exp, n_obs, idx, cyc, gaps, p;
        bit started;
        n = mode ? 16 : 8;
        ext = mode ? 0 : 1;
        len = n + ext;
        n_exp = seq_n * len;
        n_obs = 0; idx = 0; cyc = 0; gaps = 0; started = 0;
        while (n_obs < n_exp && cyc < 20000) begin
            logic cv, co, st, rdy;
            @(negedge clk);
            chip_en = ((cyc % en_period) == 0);
            sym_data = (idx < seq_n) ? 4'(seq[idx]) : 4'd0;
            vld_s = (mode == 0) && (idx < seq_n);
            vld_l = (mode == 1) && (idx < seq_n);
            #1;
            cv = mode ? cv_l : cv_s;
            co = mode ? co_l : co_s;
            st = mode ? st_l : st_s;
            rdy = mode ? rdy_l : rdy_s;
            if (started && !cv) gaps++;
            if (chip_en && cv) begin
                obs_c[n_obs] = co;
                obs_st[n_obs] = st;
                n_obs++;
                started = 1;
            end
            if (idx < seq_n && rdy) idx++;
            cyc++;
        end
        @(negedge clk);
        vld_s = 0; vld_l = 0; chip_en = 0;
        chk(n_obs == n_exp, mode ? "R4" : "R3", "chip count", n_obs, n_exp);
        if (en_period == 1)
            chk(gaps == 0, "R7", "gap cycles in back-to-back stream", gaps, 0);
        p = 0;
        for (int k = 0; k < seq_n; k++) begin
            logic [16:0] act_f, exp_f, act_s, exp_s;
            logic [15:0] w, ow;
            w = sw_word(n, seq[k]);
            act_f = '0; exp_f = '0; act_s = '0; exp_s = '0; ow = '0;
            for (int j = 0; j < len; j++) begin
                logic e;
                if (ext == 1) e = (j == 0) ? w[0] : w[n - j];
                else e = w[n - 1 - j];
                exp_f[len - 1 - j] = e;
                exp_s[len - 1 - j] = (j == 0);
                if (p + j < 1100) begin
                    act_f[len - 1 - j] = obs_c[p + j];
                    act_s[len - 1 - j] = obs_st[p + j];
                end
            end
            for (int j = 0; j < n; j++) ow[n - 1 - j] = act_f[n - 1 - j];
            if (record_words) seen[seq[k]] = ow;
            chk(act_f == exp_f, mode ? "R1/R2/R4" : "R1/R2/R3",
                $sformatf("frame of symbol %0d", seq[k]), act_f, exp_f);
            chk(act_s == exp_s, "R6", $sformatf("start marks of symbol %0d", seq[k]), act_s, exp_s);
            p += len;
        end
        if (record_words) begin
            int dup;
            dup = 0;
            for (int a = 0; a < 16; a++)
                for (int b = a + 1; b < 16; b++)
                    if (seen[a] == seen[b]) dup++;
            chk(dup == 0, "R9", "duplicate observed code words", dup, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R8: reset state of both builds.
        chk({cv_s, co_s, st_s} == 3'b000, "R8", "8-chip outputs in reset", {cv_s, co_s, st_s}, 0);
        chk({cv_l, co_l, st_l} == 3'b000, "R8", "16-chip outputs in reset", {cv_l, co_l, st_l}, 0);
        @(negedge clk);
        rst_n = 1;
        #1;
        chk(rdy_s && rdy_l, "R7", "ready while idle", {rdy_s, rdy_l}, 2'b11);

        // R1, R2: table against the software model, and symbol 0 equals the root.
        for (int v = 0; v < 16; v++)
            chk(sw_word(8, int'(VEC[v][11:8]))[7:0] == VEC[v][7:0], "R1",
                $sformatf("model word %0d", v), sw_word(8, int'(VEC[v][11:8])), VEC[v][7:0]);
        chk(sw_word(16, 0) == 16'h2F53, "R1", "16-chip symbol 0 is root", sw_word(16, 0), 16'h2F53);

        // Table walk: all symbols back-to-back, strobe every clock.
        seq_n = 16;
        for (int v = 0; v < 16; v++) seq[v] = int'(VEC[v][11:8]);
        run_stream(0, 1, 1);
        run_stream(1, 1, 1);

        // R5: sparse strobes with a different order and repeats.
        seq_n = 20;
        for (int v = 0; v < 20; v++) seq[v] = (v * 7 + 3) % 16;
        run_stream(0, 3, 0);
        run_stream(1, 2, 0);

        // R8: idle after the stream ends.
        repeat (3) @(negedge clk);
        #1;
        chk({cv_s, co_s, st_s, cv_l} == 4'b0000, "R8", "idle after stream", {cv_s, co_s, st_s, cv_l}, 0);

        // R5, R7: load symbol 5 with the strobe low; prefix chip (code 0x8B, chip 7 = 1) holds, ready low.
        @(negedge clk);
        sym_data = 4'd5; vld_s = 1; chip_en = 0;
        @(negedge clk);
        vld_s = 1; sym_data = 4'd9;
        #1;
        for (int c = 0; c < 3; c++) begin
            chk(cv_s && co_s && st_s, "R5", "held prefix chip", {cv_s, co_s, st_s}, 3'b111);
            chk(!rdy_s, "R7", "ready low mid-symbol", rdy_s, 0);
            @(negedge clk);
            #1;
        end
        // One strobe: next chip is code chip 0 = 1, start flag drops.
        chip_en = 1;
        @(negedge clk);
        chip_en = 0; vld_s = 0;
        #1;
        chk(cv_s && co_s && !st_s, "R6", "chip 0 after one strobe", {cv_s, co_s, st_s}, 3'b110);
        // R8: reset in the middle of the symbol.
        rst_n = 0;
        @(negedge clk);
        #1;
        chk({cv_s, co_s, st_s} == 3'b000, "R8", "outputs after mid-symbol reset", {cv_s, co_s, st_s}, 0);
        rst_n = 1;
        @(negedge clk);
        #1;
        chk(rdy_s, "R7", "ready after reset", rdy_s, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule